// File: doc/BRIEF.md
# Serial Program Word Loader

This block takes a program image arriving on an asynchronous serial line and turns it into a stream of 32-bit instruction words for an instruction memory. Each serial character has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line is high when idle. Every four accepted characters form one word. The first character supplies bits 31:24 and the fourth supplies bits 7:0. Each finished word is presented on a one-cycle write port together with its address. The address then moves to the next slot.

Loading stops in one of two ways. The first is a reserved end-of-program word, 32'h00000FFF, which is never written. The second is filling the last of `MAX_WORDS` slots. Once loading stops, the block raises its done flag, drops its ready output, and ignores all further line activity until a synchronous reset. The host waits for ready before it starts sending.

The receiver is built to cope with two line conditions. It rejects short low glitches as false starts. It tolerates a start bit that is held low longer than one bit time. A character whose stop bit is found low is discarded and sets a sticky framing-error flag.

Top module: `uart_word_loader`

## Requirements
- R1: While `rst` is high, and after it falls, `wrEnO`, `doneO` and `frameErrO` are 0, `wrAddrO` is 0 and `readyO` is 1.
- R2: Each character is decoded from the data bits sampled near mid-bit, with the least significant bit first. Four accepted characters form one word, with the first character placed in bits 31:24 and the last in bits 7:0.
- R3: Every non-terminator word gives exactly one `wrEnO` cycle. During that cycle `wrDataO` holds the word and `wrAddrO` holds its index counted from 0. `wrAddrO` goes up by one on the following clock.
- R4: The word 32'h00000FFF is never written. Its arrival sets `doneO`.
- R5: Once `doneO` is 1 it stays 1 until reset. Further characters, including malformed ones, produce no write and do not change `frameErrO`.
- R6: `readyO` is 1 exactly while `doneO` is 0.
- R7: A low pulse shorter than half a bit time (`CLKS_PER_BIT`/2 clocks) is not taken as a start bit. It does not disturb the alignment of the bytes that follow.
- R8: A character whose stop bit is sampled low is discarded and sets `frameErrO`. The flag stays set until reset. The next four good characters still form a correct word.
- R9: A start bit that is stretched by up to `CLKS_PER_BIT`/4 extra clocks is still decoded correctly.
- R10: After the `MAX_WORDS`-th write, `doneO` is set and no further word is written.
- R11: A reset that arrives partway through a word discards the partial bytes. The next word is assembled from four fresh characters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxSerial | input | 1 | Asynchronous serial data in, idle high |
| readyO | output | 1 | Loader can accept program data |
| wrEnO | output | 1 | One-cycle instruction write strobe |
| wrAddrO | output | $clog2(MAX_WORDS+1) | Word address of the write |
| wrDataO | output | 32 | Instruction word being written |
| doneO | output | 1 | Loading finished |
| frameErrO | output | 1 | Sticky framing-error flag |

## Verification
All results depend on the stop bit of the fourth character of a word. Counted from the falling edge of its start bit, that character passes three synchroniser and edge-detect stages, half a bit of start qualification, nine bit times to the stop sample, and two further register stages. So `wrEnO`, `doneO` and `frameErrO` change about 3 + `CLKS_PER_BIT`/2 + 9·`CLKS_PER_BIT` + 2 clocks after that edge. This is still inside the stop bit, even with the largest allowed start stretch. The bench therefore checks flags, addresses and captured writes only after a whole frame has been driven, followed by two idle clocks. A monitor samples at the falling clock edge to capture every write pulse and to check that each pulse is exactly one cycle wide.

// File: rtl/uart_loader_pkg.sv
package uart_loader_pkg;
  // strobes from control to datapath, one per clock at most
  typedef struct packed {
    logic shiftByte;  // append accepted byte to the word register
    logic writeWord;  // issue the completed word on the write port
  } ldrStrobes_t;
endpackage

// File: rtl/ldr_uart_rx.sv
module ldr_uart_rx #(
  parameter int CLKS_PER_BIT = 87,
  parameter int DATA_BITS    = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rxSerial,
  output logic                 byteValid,
  output logic [DATA_BITS-1:0] byteData,
  output logic                 frameErr
);
  localparam int CNT_W = $clog2(CLKS_PER_BIT);
  localparam int BIT_W = $clog2(DATA_BITS);
  localparam int HALF  = CLKS_PER_BIT / 2;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxState_t;

  // synchroniser chain plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncQ;
  logic lineNow, linePrev;

  always_ff @(posedge clk) begin
    if (rst) syncQ <= '1;
    else     syncQ <= {syncQ[SYNC_STAGES-1:0], rxSerial};
  end

  assign lineNow  = syncQ[SYNC_STAGES-1];
  assign linePrev = syncQ[SYNC_STAGES];

  rxState_t             stateQ;
  logic [CNT_W-1:0]     cntQ;
  logic [BIT_W-1:0]     bitIdxQ;
  logic [DATA_BITS-1:0] shiftQ;
  logic                 bitEnd, halfEnd;

  assign bitEnd  = (cntQ == CNT_W'(CLKS_PER_BIT - 1));
  assign halfEnd = (cntQ == CNT_W'(HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ    <= RX_IDLE;
      cntQ      <= '0;
      bitIdxQ   <= '0;
      shiftQ    <= '0;
      byteValid <= 1'b0;
      byteData  <= '0;
      frameErr  <= 1'b0;
    end else begin
      byteValid <= 1'b0;
      frameErr  <= 1'b0;
      case (stateQ)
        RX_IDLE: begin
          cntQ <= '0;
          if (linePrev && !lineNow) stateQ <= RX_START;
        end
        RX_START: begin
          if (halfEnd) begin
            cntQ    <= '0;
            bitIdxQ <= '0;
            // still low at mid-bit: genuine start, else a glitch
            stateQ  <= lineNow ? RX_IDLE : RX_DATA;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        RX_DATA: begin
          if (bitEnd) begin
            cntQ    <= '0;
            shiftQ  <= {lineNow, shiftQ[DATA_BITS-1:1]};
            bitIdxQ <= bitIdxQ + 1'b1;
            if (bitIdxQ == BIT_W'(DATA_BITS - 1)) stateQ <= RX_STOP;
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        RX_STOP: begin
          if (bitEnd) begin
            cntQ   <= '0;
            stateQ <= RX_IDLE;
            if (lineNow) begin
              byteValid <= 1'b1;
              byteData  <= shiftQ;
            end else begin
              frameErr <= 1'b1;
            end
          end else begin
            cntQ <= cntQ + 1'b1;
          end
        end
        default: stateQ <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldr_control.sv
module ldr_control
  import uart_loader_pkg::*;
#(
  parameter int BYTES_PER_WORD = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byteValid,
  input  logic        frameErr,
  input  logic        wordIsTerm,
  input  logic        lastSlot,
  output ldrStrobes_t strobes,
  output logic        doneQ,
  output logic        errQ
);
  localparam int BC_W = (BYTES_PER_WORD > 1) ? $clog2(BYTES_PER_WORD) : 1;

  logic [BC_W-1:0] byteCntQ;
  logic accept, lastByte;

  assign accept   = byteValid && !doneQ;
  assign lastByte = (byteCntQ == BC_W'(BYTES_PER_WORD - 1));

  always_comb begin
    strobes           = '0;
    strobes.shiftByte = accept;
    strobes.writeWord = accept && lastByte && !wordIsTerm;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byteCntQ <= '0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (accept) byteCntQ <= lastByte ? '0 : byteCntQ + 1'b1;
      if (accept && lastByte && wordIsTerm) doneQ <= 1'b1;
      if (strobes.writeWord && lastSlot)    doneQ <= 1'b1;
      if (frameErr && !doneQ)               errQ  <= 1'b1;
    end
  end
endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import uart_loader_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          BYTE_W    = 8,
  parameter int          ADDR_W    = 8,
  parameter int          MAX_WORDS = 255,
  parameter logic [31:0] TERM_WORD = 32'h00000FFF
) (
  input  logic              clk,
  input  logic              rst,
  input  ldrStrobes_t       strobes,
  input  logic [BYTE_W-1:0] byteData,
  output logic              wordIsTerm,
  output logic              lastSlot,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [WORD_W-1:0] wrData
);
  logic [WORD_W-1:0] wordQ;
  logic [WORD_W-1:0] nextWord;

  // earlier bytes move up; the newest byte takes the low end
  assign nextWord   = {wordQ[WORD_W-BYTE_W-1:0], byteData};
  assign wordIsTerm = (nextWord == WORD_W'(TERM_WORD));
  assign lastSlot   = (wrAddr == ADDR_W'(MAX_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ  <= '0;
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= strobes.writeWord;
      if (strobes.shiftByte) wordQ  <= nextWord;
      if (strobes.writeWord) wrData <= nextWord;
      if (wrEn)              wrAddr <= wrAddr + 1'b1;
    end
  end
endmodule

// File: rtl/uart_word_loader.sv
module uart_word_loader
  import uart_loader_pkg::*;
#(
  parameter int          CLKS_PER_BIT = 87,
  parameter int          MAX_WORDS    = 255,
  parameter logic [31:0] TERM_WORD    = 32'h00000FFF,
  localparam int         ADDR_W       = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxSerial,
  output logic              readyO,
  output logic              wrEnO,
  output logic [ADDR_W-1:0] wrAddrO,
  output logic [31:0]       wrDataO,
  output logic              doneO,
  output logic              frameErrO
);
  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam int BYTES_PER_WORD = WORD_W / BYTE_W;

  logic              byteValid, frameErr, wordIsTerm, lastSlot;
  logic [BYTE_W-1:0] byteData;
  ldrStrobes_t       strobes;

  ldr_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT), .DATA_BITS(BYTE_W), .SYNC_STAGES(2)) i_rx (
    .clk(clk), .rst(rst), .rxSerial(rxSerial),
    .byteValid(byteValid), .byteData(byteData), .frameErr(frameErr));

  ldr_control #(.BYTES_PER_WORD(BYTES_PER_WORD)) i_ctrl (
    .clk(clk), .rst(rst), .byteValid(byteValid), .frameErr(frameErr),
    .wordIsTerm(wordIsTerm), .lastSlot(lastSlot), .strobes(strobes),
    .doneQ(doneO), .errQ(frameErrO));

  ldr_datapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W),
                 .MAX_WORDS(MAX_WORDS), .TERM_WORD(TERM_WORD)) i_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .byteData(byteData),
    .wordIsTerm(wordIsTerm), .lastSlot(lastSlot),
    .wrEn(wrEnO), .wrAddr(wrAddrO), .wrData(wrDataO));

  assign readyO = !doneO;
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int MAX_WORDS = 255,
  parameter int ADDR_W    = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              readyO,
  input logic              wrEnO,
  input logic [ADDR_W-1:0] wrAddrO,
  input logic [31:0]       wrDataO,
  input logic              doneO,
  input logic              frameErrO
);
  // R3: a write strobe lasts exactly one cycle
  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wrEnO |=> !wrEnO);
  // R3: the address steps by one after each write
  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    wrEnO |=> (wrAddrO == $past(wrAddrO) + 1'b1));
  // R3: the address holds when no write happened
  a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
    !wrEnO |=> $stable(wrAddrO));
  // R10: writes stay inside the slot range
  a_r10_addr_range: assert property (@(posedge clk) disable iff (rst)
    wrEnO |-> (wrAddrO < ADDR_W'(MAX_WORDS)));
  // R5: done is sticky
  a_r5_done_sticky: assert property (@(posedge clk) disable iff (rst)
    doneO |=> doneO);
  // R5: no write once done was already set
  a_r5_no_write_after_done: assert property (@(posedge clk) disable iff (rst)
    doneO |=> !wrEnO);
  // R8: the framing error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    frameErrO |=> frameErrO);
  // R5: the error flag cannot rise after done
  a_r5_err_frozen: assert property (@(posedge clk) disable iff (rst)
    doneO |=> $stable(frameErrO));
  // R6: ready falls together with the rise of done
  a_r6_ready_drop: assert property (@(posedge clk) disable iff (rst)
    $rose(doneO) |-> $fell(readyO));
endmodule

bind uart_word_loader ldr_checker #(.MAX_WORDS(MAX_WORDS), .ADDR_W(ADDR_W)) i_ldr_checker (
  .clk(clk), .rst(rst), .readyO(readyO), .wrEnO(wrEnO), .wrAddrO(wrAddrO),
  .wrDataO(wrDataO), .doneO(doneO), .frameErrO(frameErrO));

// File: tb/test_uart_word_loader.sv
module test_uart_word_loader;
  localparam int CPB    = 16;
  localparam int MAXW   = 6;
  localparam int ADDR_W = $clog2(MAXW + 1);
  localparam logic [31:0] TERM = 32'h00000FFF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxSerial = 1'b1;
  logic readyO, wrEnO, doneO, frameErrO;
  logic [ADDR_W-1:0] wrAddrO;
  logic [31:0] wrDataO;

  always #2 clk = ~clk;

  uart_word_loader #(.CLKS_PER_BIT(CPB), .MAX_WORDS(MAXW), .TERM_WORD(TERM)) i_uart_word_loader (
    .clk(clk), .rst(rst), .rxSerial(rxSerial), .readyO(readyO), .wrEnO(wrEnO),
    .wrAddrO(wrAddrO), .wrDataO(wrDataO), .doneO(doneO), .frameErrO(frameErrO));

  int checks = 0;
  int fails  = 0;
  int capCount = 0;
  logic [31:0] capData [16];
  logic [31:0] capAddr [16];
  logic prevWe = 1'b0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // write monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && wrEnO) begin
      if (capCount < 16) begin
        capData[capCount] = wrDataO;
        capAddr[capCount] = 32'(wrAddrO);
      end
      capCount++;
      if (prevWe) check(1'b0, "R3 pulse width", 32'd1, 32'd0);
    end
    prevWe = wrEnO && !rst;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<190000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rxSerial = 1'b1;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    capCount = 0;
    idle(2);
  endtask

  task automatic sendByte(input logic [7:0] d, input int stretch, input bit badStop);
    rxSerial = 1'b0;
    idle(CPB + stretch);
    for (int i = 0; i < 8; i++) begin
      rxSerial = d[i];
      idle(CPB);
    end
    rxSerial = badStop ? 1'b0 : 1'b1;
    idle(CPB);
    rxSerial = 1'b1;
    if (badStop) idle(CPB);
  endtask

  task automatic sendWord(input logic [31:0] w, input int stretch);
    for (int b = 3; b >= 0; b--) sendByte(w[b*8 +: 8], stretch, 1'b0);
    idle(2);
  endtask

  function automatic logic [31:0] patWord(input int k);
    return (32'h1 << (k % 32)) ^ (32'(k) * 32'h9E3779B9);
  endfunction

  initial begin
    int n;
    logic [31:0] w;
    // R1: reset state
    idle(3);
    check(readyO == 1'b1 && wrEnO == 1'b0, "R1 ready/we in reset", {30'd0, readyO, wrEnO}, 32'd2);
    rst = 1'b0;
    idle(2);
    check(doneO == 1'b0 && frameErrO == 1'b0, "R1 flags", {30'd0, doneO, frameErrO}, 32'd0);
    check(wrAddrO == '0, "R1 address", 32'(wrAddrO), 32'd0);
    check(readyO == 1'b1, "R6 ready before done", 32'(readyO), 32'd1);

    // R2 R3 R4 R9: sweep of word patterns, counts and start stretches
    for (int run = 0; run < 8; run++) begin
      doReset();
      n = 1 + run % 4;
      for (int k = 0; k < n; k++) sendWord(patWord(run * 8 + k), (run + k) % 5);
      check(doneO == 1'b0, "R4 not done before terminator", 32'(doneO), 32'd0);
      sendWord(TERM, run % 5);
      check(capCount == n, "R4 terminator not written", 32'(capCount), 32'(n));
      for (int k = 0; k < n; k++) begin
        check(capData[k] == patWord(run * 8 + k), "R2 R9 word data", capData[k], patWord(run * 8 + k));
        check(capAddr[k] == 32'(k), "R3 write address", capAddr[k], 32'(k));
      end
      check(doneO == 1'b1, "R4 done after terminator", 32'(doneO), 32'd1);
      check(readyO == 1'b0, "R6 ready after done", 32'(readyO), 32'd0);
      check(32'(wrAddrO) == 32'(n), "R3 final address", 32'(wrAddrO), 32'(n));
    end

    // R5: traffic after done is ignored
    sendWord(32'hCAFEF00D, 0);
    sendByte(8'h55, 0, 1'b1);
    idle(2);
    check(capCount == 4, "R5 no write after done", 32'(capCount), 32'd4);
    check(frameErrO == 1'b0, "R5 error unchanged after done", 32'(frameErrO), 32'd0);
    check(doneO == 1'b1, "R5 done held", 32'(doneO), 32'd1);

    // R10: word limit
    doReset();
    for (int k = 0; k < MAXW; k++) sendWord(patWord(100 + k), 0);
    check(doneO == 1'b1, "R10 done at limit", 32'(doneO), 32'd1);
    sendWord(32'h11223344, 0);
    check(capCount == MAXW, "R10 no write past limit", 32'(capCount), 32'(MAXW));
    check(capData[MAXW-1] == patWord(100 + MAXW - 1), "R10 last word", capData[MAXW-1], patWord(100 + MAXW - 1));

    // R7: short glitch ignored
    doReset();
    rxSerial = 1'b0;
    idle(CPB / 2 - 5);
    rxSerial = 1'b1;
    idle(2 * CPB);
    check(capCount == 0 && frameErrO == 1'b0, "R7 glitch no effect", 32'(capCount), 32'd0);
    sendWord(32'h80FF0102, 0);
    check(capCount == 1 && capData[0] == 32'h80FF0102, "R7 alignment kept", capData[0], 32'h80FF0102);

    // R8: bad stop bit discards the byte and sets the flag
    doReset();
    sendByte(8'hA7, 0, 1'b1);
    idle(2);
    check(frameErrO == 1'b1, "R8 error set", 32'(frameErrO), 32'd1);
    check(capCount == 0, "R8 no write", 32'(capCount), 32'd0);
    sendWord(32'h0BADBEEF, 0);
    check(capCount == 1 && capData[0] == 32'h0BADBEEF, "R8 next word intact", capData[0], 32'h0BADBEEF);
    check(frameErrO == 1'b1, "R8 error sticky", 32'(frameErrO), 32'd1);

    // R11: reset in the middle of a word
    doReset();
    sendByte(8'hDE, 0, 1'b0);
    sendByte(8'hAD, 0, 1'b0);
    doReset();
    check(frameErrO == 1'b0, "R1 reset clears error", 32'(frameErrO), 32'd0);
    w = 32'h76543210;
    sendWord(w, 0);
    check(capCount == 1 && capData[0] == w, "R11 fresh word", capData[0], w);
    check(capAddr[0] == 32'd0, "R11 address restarts", capAddr[0], 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule